// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the device-side end of a three-wire configuration bus. The host drives a serial clock, a serial data line and an active-low enable. The slave answers on a serial output that it drives only while it returns read data. The slave runs on a fast system clock. It brings the three host lines in through two-flop synchronizers and finds the serial clock edges from the synchronized samples.

Each transaction is a frame of serial bits:

1. a start bit of 0;
2. a direction bit, where 0 means write and 1 means read;
3. a 5-bit register address;
4. 8 data bits;
5. two stop bits of 1.

Writes land in a bank of shadow registers, which have no effect on the configuration outputs. The whole shadow bank is copied into the live registers when the enable line returns high. A host can therefore stage several register writes inside one enable-low window and apply them all at once.

Register 0 is special: it holds a single bit. Reads return the addressed live register, most significant bit first.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset every live register equals the default value `RST_VAL` (0xA5). Register 0 reads as `{RST_VAL[7], 7'b1111111}`. The output enable `sdo_oe_o` is low.
- R2: The serial input is sampled on each falling serial clock edge. A frame is built from these samples in this order: a start bit 0, a direction bit (0 = write), 5 address bits MSB first, 8 data bits MSB first, and two stop bits of 1.
- R3: A completed write frame changes only the shadow register. `cfg_o` stays unchanged for as long as enable remains low.
- R4: On each rising edge of enable, all shadow registers are copied into the live registers on `cfg_o`. Register i appears at bits `[8*i+7 : 8*i]`.
- R5: Several frames may follow one another in one enable-low window. Each one is accepted when the serial input is sampled at 1 at least once after the two stop bits of the frame before it.
- R6: Register 0 keeps only the data MSB of a write, and its lower 7 data bits are ignored. Its live word, on `cfg_o` and on reads, is that bit followed by seven ones.
- R7: A frame with direction bit 1 returns the addressed live register, not its pending shadow value, MSB first on `sdo_o`. The first bit is driven on the first rising serial clock edge after the address LSB, and each later rising edge drives the next bit. The host samples each bit on the falling edge.
- R8: `sdo_oe_o` is high only during the 8 data bits of a read frame. It is low during the address and stop bits, and whenever enable is high.
- R9: If either stop bit is sampled as 0, the frame is discarded and no shadow register changes.
- R10: If enable rises in the middle of a frame, that frame is aborted. Shadow writes that were already completed in the same window are still committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| en_ni | input | 1 | Active-low transaction enable; its rising edge commits the shadow registers |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for the serial data pad; low means high impedance |
| cfg_o | output | 256 | Live register file, with register i at bits [8*i+7 : 8*i] |

## Verification
Directed frames check the features one at a time:

- a single write that is held back until enable rises;
- a burst of back-to-back writes in one window;
- writes to register 0 with the lower data bits set to 0 and with the MSB flipped;
- a read issued right after a write to the same register, to tell the live value apart from the shadow value;
- frames with a bad first stop bit and with a bad second stop bit;
- a frame cut short by enable rising.

Constrained-random windows then mix reads and writes to random addresses, and sometimes corrupt a stop bit. They compare every read word and the full register file after each commit against a bench model. The read checks also sample the output enable on every bit of every frame, which separates a bit-alignment error from a value error.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  typedef enum logic [2:0] {
    ST_ARMED,
    ST_RW,
    ST_ADDR,
    ST_DATA,
    ST_STOP1,
    ST_STOP2,
    ST_WAIT_IDLE
  } rx_state_e;
endpackage

// File: rtl/cfg_ser_sync.sv
module cfg_ser_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/cfg_ser_frame_rx.sv
module cfg_ser_frame_rx
  import cfg_ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              en_idle_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              sck_rise_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int unsigned CNT_W = $clog2(MAX_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] tx_q;
  logic              sck_q, en_q;
  logic              sck_rise, sck_fall;

  assign sck_rise   = sck_i & ~sck_q;
  assign sck_fall   = ~sck_i & sck_q;
  assign sck_rise_o = sck_rise;
  assign rd_addr_o  = {addr_q[ADDR_W-2:0], sdi_i};
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ARMED;
      cnt_q    <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      tx_q     <= '0;
      sck_q    <= 1'b1;
      en_q     <= 1'b1;
      wr_en_o  <= 1'b0;
      commit_o <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      sck_q    <= sck_i;
      en_q     <= en_idle_i;
      wr_en_o  <= 1'b0;
      commit_o <= en_idle_i & ~en_q;
      if (en_idle_i) begin
        // enable high: abort any frame, release the pad
        state_q  <= ST_ARMED;
        sdo_oe_o <= 1'b0;
      end else begin
        if (sck_rise && state_q == ST_DATA && rw_q) begin
          sdo_o    <= tx_q[DATA_W-1];
          tx_q     <= {tx_q[DATA_W-2:0], 1'b1};
          sdo_oe_o <= 1'b1;
        end
        if (sck_fall) begin
          unique case (state_q)
            ST_ARMED: if (!sdi_i) state_q <= ST_RW;
            ST_RW: begin
              rw_q    <= sdi_i;
              cnt_q   <= '0;
              state_q <= ST_ADDR;
            end
            ST_ADDR: begin
              addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
              if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                cnt_q   <= '0;
                state_q <= ST_DATA;
                if (rw_q) tx_q <= rd_data_i;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_DATA: begin
              data_q <= {data_q[DATA_W-2:0], sdi_i};
              if (cnt_q == CNT_W'(DATA_W - 1)) begin
                state_q  <= ST_STOP1;
                sdo_oe_o <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
            ST_STOP1: state_q <= sdi_i ? ST_STOP2 : ST_WAIT_IDLE;
            ST_STOP2: begin
              if (sdi_i && !rw_q) wr_en_o <= 1'b1;
              state_q <= ST_WAIT_IDLE;
            end
            ST_WAIT_IDLE: if (sdi_i) state_q <= ST_ARMED;
            default: state_q <= ST_WAIT_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_ser_regfile.sv
module cfg_ser_regfile #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = 8'hA5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             commit_i,
  input  logic [ADDR_W-1:0]                rd_addr_i,
  output logic [DATA_W-1:0]                rd_data_o,
  output logic [(DATA_W<<ADDR_W)-1:0]      cfg_o
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] live_w [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));
    if (i == 0) begin : g_bit
      // one-bit register: MSB kept, ones below
      logic shadow_q, live_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shadow_q <= RST_VAL[DATA_W-1];
          live_q   <= RST_VAL[DATA_W-1];
        end else begin
          if (hit)      shadow_q <= wr_data_i[DATA_W-1];
          if (commit_i) live_q   <= shadow_q;
        end
      end
      assign live_w[i] = {live_q, {(DATA_W-1){1'b1}}};
    end else begin : g_word
      logic [DATA_W-1:0] shadow_q, live_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          shadow_q <= RST_VAL;
          live_q   <= RST_VAL;
        end else begin
          if (hit)      shadow_q <= wr_data_i;
          if (commit_i) live_q   <= shadow_q;
        end
      end
      assign live_w[i] = live_q;
    end
    assign cfg_o[i*DATA_W +: DATA_W] = live_w[i];
  end

  assign rd_data_o = live_w[rd_addr_i];
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = 8'hA5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sck_i,
  input  logic                        sdi_i,
  input  logic                        en_ni,
  output logic                        sdo_o,
  output logic                        sdo_oe_o,
  output logic [(DATA_W<<ADDR_W)-1:0] cfg_o
);
  logic [2:0]        sync_s;
  logic              sck_s, sdi_s, en_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, commit, sck_rise;

  cfg_ser_sync #(.WIDTH(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_ni, sdi_i, sck_i}),
    .q_o   (sync_s)
  );
  assign sck_s = sync_s[0];
  assign sdi_s = sync_s[1];
  assign en_s  = sync_s[2];

  cfg_ser_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (sck_s),
    .sdi_i     (sdi_s),
    .en_idle_i (en_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .commit_o  (commit),
    .sck_rise_o(sck_rise),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o)
  );

  cfg_ser_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .commit_i (commit),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .cfg_o    (cfg_o)
  );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int unsigned CFG_W = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_s,
  input logic             sck_rise,
  input logic             wr_en,
  input logic             commit,
  input logic             sdo_oe_o,
  input logic [CFG_W-1:0] cfg_o
);
  assert_oe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s |=> !sdo_oe_o);

  assert_live_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(cfg_o));

  assert_oe_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(sck_rise));

  assert_no_wr_at_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && commit));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.CFG_W(DATA_W << ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_s    (en_s),
  .sck_rise(sck_rise),
  .wr_en   (wr_en),
  .commit  (commit),
  .sdo_oe_o(sdo_oe_o),
  .cfg_o   (cfg_o)
);

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NREG       = 32;
  localparam logic [7:0] DEF = 8'hA5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sck = 1'b1, sdi = 1'b1, en_n = 1'b1;
  logic         sdo, sdo_oe;
  logic [255:0] cfg;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] shadow_m [NREG];
  logic [7:0] live_m   [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .sdi_i(sdi), .en_ni(en_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .cfg_o(cfg)
  );

  function automatic logic [7:0] reg_val(input logic [4:0] a, input logic [7:0] d);
    return (a == 5'd0) ? {d[7], 7'h7f} : d;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_cfg(input string req);
    int bad = -1;
    for (int i = 0; i < NREG; i++)
      if (bad < 0 && cfg[i*8 +: 8] !== live_m[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, longint'(cfg[bad*8 +: 8]), longint'(live_m[bad]));
  endtask

  task automatic send_bit(input logic b, output logic so, output logic oe);
    sdi = b;
    wait_clk(HALF);
    so = sdo;
    oe = sdo_oe;
    sck = 1'b0;
    wait_clk(HALF);
    sck = 1'b1;
  endtask

  // full frame is 17 bits; nbits < 17 truncates it
  task automatic frame(input logic rw, input logic [4:0] a, input logic [7:0] d,
                       input logic s1, input logic s2, input int nbits, input string req);
    logic [16:0] v;
    logic [7:0]  rd, exp;
    logic        so, oe;
    bit          oe_bad;
    v = {1'b0, rw, a, d, s1, s2};
    exp = live_m[a];
    rd = '0;
    oe_bad = 0;
    for (int i = 0; i < nbits; i++) begin
      send_bit(v[16-i], so, oe);
      if (rw && i >= 7 && i < 15) begin
        rd = {rd[6:0], so};
        if (oe !== 1'b1) oe_bad = 1;
      end else if (oe !== 1'b0) oe_bad = 1;
    end
    if (nbits == 17) begin
      if (rw) begin
        chk(rd === exp, {req, " read data"}, longint'(rd), longint'(exp));
        chk(!oe_bad, "R8 output enable window", longint'(oe_bad), 0);
      end else if (s1 && s2) begin
        shadow_m[a] = reg_val(a, d);
      end
      send_bit(1'b1, so, oe);
    end
  endtask

  task automatic en_low();
    en_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic en_high();
    en_n = 1'b1;
    wait_clk(10);
    for (int i = 0; i < NREG; i++) live_m[i] = shadow_m[i];
  endtask

  task automatic finish_tb();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_tb();
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < NREG; i++) begin
      shadow_m[i] = reg_val(5'(i), DEF);
      live_m[i]   = shadow_m[i];
    end
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    check_cfg("R1 reset register file");
    chk(sdo_oe === 1'b0, "R1 output enable at reset", longint'(sdo_oe), 0);

    // R2 R3 R4: single write held back until commit
    en_low();
    frame(1'b0, 5'd3, 8'h3C, 1, 1, 17, "R2");
    wait_clk(10);
    check_cfg("R3 live unchanged before commit");
    en_high();
    check_cfg("R4 commit of single write");
    chk(cfg[3*8 +: 8] === 8'h3C, "R2 frame field decode", longint'(cfg[3*8 +: 8]), 'h3C);
    chk(sdo_oe === 1'b0, "R8 released with enable high", longint'(sdo_oe), 0);

    // R5 back-to-back writes
    en_low();
    frame(1'b0, 5'd5, 8'h11, 1, 1, 17, "R5");
    frame(1'b0, 5'd7, 8'h22, 1, 1, 17, "R5");
    frame(1'b0, 5'd31, 8'hFF, 1, 1, 17, "R5");
    en_high();
    check_cfg("R5 burst in one window");

    // R6 register 0
    en_low();
    frame(1'b0, 5'd0, 8'h00, 1, 1, 17, "R6");
    en_high();
    chk(cfg[7:0] === 8'h7F, "R6 reg0 clear", longint'(cfg[7:0]), 'h7F);
    en_low();
    frame(1'b1, 5'd0, 8'hFF, 1, 1, 17, "R6 reg0 read");
    frame(1'b0, 5'd0, 8'h80, 1, 1, 17, "R6");
    en_high();
    chk(cfg[7:0] === 8'hFF, "R6 reg0 set", longint'(cfg[7:0]), 'hFF);

    // R7 read returns live, not shadow
    en_low();
    frame(1'b0, 5'd9, 8'h5A, 1, 1, 17, "R7");
    frame(1'b1, 5'd9, 8'h00, 1, 1, 17, "R7 read before commit");
    en_high();
    en_low();
    frame(1'b1, 5'd9, 8'h00, 1, 1, 17, "R7 read after commit");
    en_high();

    // R9 bad stop bits
    en_low();
    frame(1'b0, 5'd12, 8'h00, 0, 1, 17, "R9");
    frame(1'b0, 5'd13, 8'h00, 1, 0, 17, "R9");
    frame(1'b1, 5'd14, 8'h00, 1, 1, 17, "R9 frame after bad stop");
    en_high();
    check_cfg("R9 bad stop discarded");

    // R10 abort mid-frame
    en_low();
    frame(1'b0, 5'd20, 8'h77, 1, 1, 17, "R10");
    frame(1'b0, 5'd21, 8'h66, 1, 1, 10, "R10");
    en_high();
    check_cfg("R10 abort keeps completed writes");
    en_low();
    frame(1'b0, 5'd21, 8'h44, 1, 1, 17, "R10");
    en_high();
    check_cfg("R10 recovery after abort");

    // random windows
    for (int w = 0; w < 30; w++) begin
      int nf;
      en_low();
      nf = 1 + int'($urandom % 3);
      for (int f = 0; f < nf; f++) begin
        logic rw, s1, s2;
        logic [4:0] a;
        logic [7:0] d;
        rw = 1'($urandom % 2);
        a  = 5'($urandom);
        d  = 8'($urandom);
        s1 = ($urandom % 8) != 0;
        s2 = ($urandom % 8) != 0;
        frame(rw, a, d, s1, s2, 17, rw ? "R7 random" : "R2");
      end
      en_high();
      check_cfg("R4 random commit");
    end

    finish_tb();
  end
endmodule